// File: doc/BRIEF.md
# I2S Clock Ratio Generator

This block produces the serial-audio timing of a transmit or receive port from one fast master clock. A prescaler divides the master clock down to the audio root rate. The bit clock runs at a ratio of that root rate that can be changed at run time. The frame (left/right) clock is derived by counting bit clocks. All of this logic runs on the master clock. The divided clocks exist as registered levels that move on clock-enable ticks, so the block needs no extra clock domains.

In master mode the block drives the bit and frame clocks and states, through `cdclk_oe_o`, that the codec clock leaves the chip. In slave mode the bit and frame clocks come from outside and are synchronised. The block then only reports the bit position within the frame and a frame-start strobe. It keeps its own clock outputs low in this mode.

Two ratio selectors set the timing. One picks the root clock as a multiple of the sample rate; an unknown code falls back to 256. The other picks the number of bit clocks per frame; an unknown code is ignored. A root/bit pair whose quotient is not an even whole number stops the generator and raises a flag.

Top module: `i2s_ratio_clkgen`

## Requirements
- R1: `root_sel_i` codes 0, 1, 2, 3 select a root ratio of 256, 384, 512, 768 times the sample rate, and codes 4 to 7 select 256; the new code takes effect one clock after it is presented.
- R2: `bfs_sel_i` codes 0, 1, 2, 3 select 16, 24, 32, 48 bit clocks per frame; codes 4 to 7 leave the ratio in force unchanged.
- R3: With `psc_en_i` high, a root tick occurs once every `psc_val_i`+1 master clocks; with `psc_en_i` low, every master clock is a root tick.
- R4: In master mode with a valid pair, `bclk_o` toggles every (root/bits)/2 root ticks, starting low after reset or after any stop, with its first transition rising.
- R5: When root/bits is not a whole number, `ratio_bad_o` is 1, and `bclk_o`, `fclk_o` and `frame_start_o` stay 0 while `bit_idx_o` stays 63.
- R6: In master mode `bit_idx_o` changes in the same cycle that `bclk_o` goes from 1 to 0. It steps by one and wraps from bits-1 (or any larger value) to 0. Its idle value is 63.
- R7: `fclk_o` is 0 while the bit index is below bits/2 and 1 otherwise. `frame_start_o` pulses for one cycle when the index becomes 0.
- R8: In slave mode `bclk_o` and `fclk_o` are 0. The external clocks pass through two synchronising flops. On each synchronised falling bit-clock edge the index advances modulo 64, or returns to 0 with a one-cycle `frame_start_o` if the synchronised frame clock went from 1 to 0 since the previous falling edge. The index is 63 on entry to slave mode.
- R9: `cdclk_oe_o` is 1 in master mode and 0 in slave mode.
- R10: The reset is synchronous and active low. It selects 256 and 32 and leaves all clock outputs 0, `bit_idx_o` at 63 and `ratio_bad_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | synchronous reset, active low |
| psc_en_i | input | 1 | prescaler enable |
| psc_val_i | input | PSC_W | prescaler divide value minus one |
| root_sel_i | input | 3 | root ratio code |
| bfs_sel_i | input | 3 | bit-clock ratio code |
| slave_i | input | 1 | 1 = slave mode, 0 = master mode |
| bclk_ext_i | input | 1 | external bit clock (slave) |
| fclk_ext_i | input | 1 | external frame clock (slave) |
| bclk_o | output | 1 | generated bit clock |
| fclk_o | output | 1 | generated frame clock |
| bit_idx_o | output | 6 | bit position within the frame |
| frame_start_o | output | 1 | one-cycle frame start strobe |
| ratio_bad_o | output | 1 | root/bit pair does not divide evenly |
| cdclk_oe_o | output | 1 | codec clock driven outward |

## Verification
The embedded properties check several rules on every clock: the root-code fallback, the hold of the bit ratio on unknown codes, and the absence of back-to-back prescaler ticks when dividing. They also check that the generator idles while stopped, that the index either steps by one or wraps and moves on every bit-clock fall, that a frame start coincides with index 0 and a low frame clock, and that the slave index holds between external falling edges. Only the bench scenarios can show the exact periods: the bit-clock half period for each ratio pair, with and without the prescaler, the frame length and frame-clock phase, and the three-clock slave latency. These are compared each cycle against a behavioural model.

// File: rtl/audio_clk_pkg.sv
// Package: shared ratio types and the half-period lookup for the I2S
// clock ratio generator. Assumes ratio codes of two bits after fallback.
package audio_clk_pkg;

    localparam int IDX_W  = 6;   // bit index width, holds up to 63
    localparam int HALF_W = 5;   // half-period counter width, holds up to 31
    localparam int CODE_W = 3;   // width of the ratio request codes

    typedef enum logic [1:0] {RT_256 = 2'd0, RT_384 = 2'd1, RT_512 = 2'd2, RT_768 = 2'd3} root_e;
    typedef enum logic [1:0] {BF_16 = 2'd0, BF_24 = 2'd1, BF_32 = 2'd2, BF_48 = 2'd3} bfs_e;

    // Bit clocks per frame for a bit ratio.
    function automatic logic [IDX_W-1:0] bits_per_frame(bfs_e b);
        case (b)
            BF_16:   return IDX_W'(16);
            BF_24:   return IDX_W'(24);
            BF_32:   return IDX_W'(32);
            default: return IDX_W'(48);
        endcase
    endfunction

    // Root ticks per bit-clock half period; zero marks a pair that does not divide.
    function automatic logic [HALF_W-1:0] half_period(root_e r, bfs_e b);
        case ({r, b})
            4'b00_00: return HALF_W'(8);
            4'b00_10: return HALF_W'(4);
            4'b01_00: return HALF_W'(12);
            4'b01_01: return HALF_W'(8);
            4'b01_10: return HALF_W'(6);
            4'b01_11: return HALF_W'(4);
            4'b10_00: return HALF_W'(16);
            4'b10_10: return HALF_W'(8);
            4'b11_00: return HALF_W'(24);
            4'b11_01: return HALF_W'(16);
            4'b11_10: return HALF_W'(12);
            4'b11_11: return HALF_W'(8);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/i2s_ratio_cfg.sv
// Ratio configuration: registers the root and bit-clock ratio requests.
// Unknown root codes fall back to 256; unknown bit codes are ignored.
// Assumes codes are held stable by the caller between changes.
module i2s_ratio_cfg
    import audio_clk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] root_sel_i,
    input  logic [CODE_W-1:0] bfs_sel_i,
    output logic [HALF_W-1:0] half_o,
    output logic [IDX_W-1:0]  bfs_n_o,
    output logic              bad_o
);

    root_e root_q;
    bfs_e  bfs_q;

    // Capture the requested ratios with fallback and hold rules.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            root_q <= RT_256;
            bfs_q  <= BF_32;
        end else begin
            root_q <= root_sel_i[CODE_W-1] ? RT_256 : root_e'(root_sel_i[1:0]);
            if (!bfs_sel_i[CODE_W-1]) begin
                bfs_q <= bfs_e'(bfs_sel_i[1:0]);
            end
        end
    end

    // Derive half period, frame length and validity from the held ratios.
    always_comb begin
        half_o  = half_period(root_q, bfs_q);
        bfs_n_o = bits_per_frame(bfs_q);
        bad_o   = (half_o == '0);
    end

    p_root_fallback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        root_sel_i[CODE_W-1] |=> (root_q == RT_256));

    p_bfs_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bfs_sel_i[CODE_W-1] |=> $stable(bfs_q));

endmodule

// File: rtl/i2s_root_prescaler.sv
// Root prescaler: emits a one-cycle tick every val+1 master clocks when
// enabled, and a tick on every clock when disabled. Assumes val is held
// stable while enabled.
module i2s_root_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [PSC_W-1:0] val_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] cnt_q;

    // Tick when the count reaches the divide value, or always when bypassed.
    always_comb tick_o = !en_i || (cnt_q == val_i);

    // Count master clocks between ticks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PSC_W'(1);
        end
    end

    p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_o && val_i != '0) |-> !$past(tick_o) || !$past(en_i));

endmodule

// File: rtl/i2s_bclk_master.sv
// Master timing: divides root ticks into the bit clock, counts bit
// clocks into the frame index and derives the frame clock and strobe.
// Assumes half_i is non-zero whenever run_i is high.
module i2s_bclk_master
    import audio_clk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic [IDX_W-1:0]  bfs_n_i,
    output logic              bclk_o,
    output logic              fclk_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              fs_o
);

    logic              bclk_q, fclk_q, fs_q;
    logic [HALF_W-1:0] hcnt_q;
    logic [IDX_W-1:0]  idx_q, nxt_idx;

    // Next bit index, wrapping at or beyond the last bit of the frame.
    always_comb nxt_idx = (idx_q >= bfs_n_i - IDX_W'(1)) ? '0 : idx_q + IDX_W'(1);

    // Half-period counting, bit clock toggle and index update on falls.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i) begin
            bclk_q <= 1'b0;
            fclk_q <= 1'b0;
            fs_q   <= 1'b0;
            hcnt_q <= '0;
            idx_q  <= '1;
        end else begin
            fs_q <= 1'b0;
            if (tick_i) begin
                if (hcnt_q >= half_i - HALF_W'(1)) begin
                    hcnt_q <= '0;
                    bclk_q <= ~bclk_q;
                    if (bclk_q) begin
                        idx_q  <= nxt_idx;
                        fclk_q <= (nxt_idx >= (bfs_n_i >> 1));
                        fs_q   <= (nxt_idx == '0);
                    end
                end else begin
                    hcnt_q <= hcnt_q + HALF_W'(1);
                end
            end
        end
    end

    assign bclk_o = bclk_q;
    assign fclk_o = fclk_q;
    assign idx_o  = idx_q;
    assign fs_o   = fs_q;

    p_stop_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!bclk_q && !fs_q && idx_q == '1));

    p_idx_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run_i) && idx_q != $past(idx_q)) |-> (idx_q == '0 || idx_q == $past(idx_q) + IDX_W'(1)));

    p_fall_moves_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run_i) && $fell(bclk_q)) |-> (idx_q != $past(idx_q)));

    p_start_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fs_q |-> (idx_q == '0 && !fclk_q));

endmodule

// File: rtl/i2s_slave_track.sv
// Slave tracker: synchronises external bit and frame clocks and counts
// synchronised bit-clock falls into a frame index; a frame-clock fall
// seen between bit-clock falls restarts the index. Assumes the external
// clocks are slower than a quarter of the master clock.
module i2s_slave_track
    import audio_clk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             bclk_ext_i,
    input  logic             fclk_ext_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             fs_o
);

    logic [1:0]       bsync_q, fsync_q;
    logic             bclk_d_q, fprev_q, fs_q, fall_w;
    logic [IDX_W-1:0] idx_q;

    // Two-flop synchronisers and a delayed copy for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bsync_q  <= '0;
            fsync_q  <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            bsync_q  <= {bsync_q[0], bclk_ext_i};
            fsync_q  <= {fsync_q[0], fclk_ext_i};
            bclk_d_q <= bsync_q[1];
        end
    end

    // Falling edge of the synchronised bit clock.
    always_comb fall_w = bclk_d_q && !bsync_q[1];

    // Index and frame-start tracking on each bit-clock fall.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            idx_q   <= '1;
            fprev_q <= 1'b0;
            fs_q    <= 1'b0;
        end else begin
            fs_q <= 1'b0;
            if (fall_w) begin
                fprev_q <= fsync_q[1];
                if (fprev_q && !fsync_q[1]) begin
                    idx_q <= '0;
                    fs_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    assign idx_o = idx_q;
    assign fs_o  = fs_q;

    p_slave_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(en_i) && !$past(fall_w)) |-> $stable(idx_q));

endmodule

// File: rtl/i2s_ratio_clkgen.sv
// Top: I2S clock ratio generator. Combines ratio configuration, root
// prescaler, master bit/frame generator and slave tracker, and selects
// the outputs by mode. Assumes all inputs are synchronous to clk_i
// except the external clocks.
module i2s_ratio_clkgen
    import audio_clk_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             psc_en_i,
    input  logic [PSC_W-1:0] psc_val_i,
    input  logic [2:0]       root_sel_i,
    input  logic [2:0]       bfs_sel_i,
    input  logic             slave_i,
    input  logic             bclk_ext_i,
    input  logic             fclk_ext_i,
    output logic             bclk_o,
    output logic             fclk_o,
    output logic [5:0]       bit_idx_o,
    output logic             frame_start_o,
    output logic             ratio_bad_o,
    output logic             cdclk_oe_o
);

    logic [HALF_W-1:0] half_w;
    logic [IDX_W-1:0]  bfs_n_w, m_idx_w, s_idx_w;
    logic              bad_w, tick_w, run_w;
    logic              m_bclk_w, m_fclk_w, m_fs_w, s_fs_w;

    i2s_ratio_cfg u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .root_sel_i (root_sel_i),
        .bfs_sel_i  (bfs_sel_i),
        .half_o     (half_w),
        .bfs_n_o    (bfs_n_w),
        .bad_o      (bad_w)
    );

    i2s_root_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (psc_en_i),
        .val_i  (psc_val_i),
        .tick_o (tick_w)
    );

    // Generator runs only in master mode with a dividing ratio pair.
    always_comb run_w = !slave_i && !bad_w;

    i2s_bclk_master u_mst (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_w),
        .tick_i  (tick_w),
        .half_i  (half_w),
        .bfs_n_i (bfs_n_w),
        .bclk_o  (m_bclk_w),
        .fclk_o  (m_fclk_w),
        .idx_o   (m_idx_w),
        .fs_o    (m_fs_w)
    );

    i2s_slave_track u_slv (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (slave_i),
        .bclk_ext_i (bclk_ext_i),
        .fclk_ext_i (fclk_ext_i),
        .idx_o      (s_idx_w),
        .fs_o       (s_fs_w)
    );

    // Mode-dependent output selection.
    always_comb begin
        bclk_o        = slave_i ? 1'b0 : m_bclk_w;
        fclk_o        = slave_i ? 1'b0 : m_fclk_w;
        bit_idx_o     = slave_i ? s_idx_w : m_idx_w;
        frame_start_o = slave_i ? s_fs_w : m_fs_w;
        ratio_bad_o   = bad_w;
        cdclk_oe_o    = !slave_i;
    end

endmodule

// File: tb/tb_i2s_ratio_clkgen.sv
module tb_i2s_ratio_clkgen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       psc_en;
    logic [7:0] psc_val;
    logic [2:0] root_sel, bfs_sel;
    logic       slave, bclk_ext, fclk_ext;
    logic       bclk, fclk, fstart, rbad, oe;
    logic [5:0] idx;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    string tag = "R10";

    // behavioural model state
    int m_root = 256, m_bfs = 32, m_pc = 0, m_hc = 0, m_idx = 63;
    bit m_bclk = 0, m_fclk = 0, m_fs = 0;
    int s_idx = 63;
    bit s_fs = 0, s_fprev = 0, sb1 = 0, sb2 = 0, sbd = 0, sf1 = 0, sf2 = 0;

    always #5 clk = ~clk;

    i2s_ratio_clkgen dut (
        .clk_i(clk), .rst_ni(rst_n), .psc_en_i(psc_en), .psc_val_i(psc_val),
        .root_sel_i(root_sel), .bfs_sel_i(bfs_sel), .slave_i(slave),
        .bclk_ext_i(bclk_ext), .fclk_ext_i(fclk_ext),
        .bclk_o(bclk), .fclk_o(fclk), .bit_idx_o(idx), .frame_start_o(fstart),
        .ratio_bad_o(rbad), .cdclk_oe_o(oe)
    );

    function automatic int root_of(int code);
        case (code)
            1: return 384;
            2: return 512;
            3: return 768;
            default: return 256;
        endcase
    endfunction

    function automatic int bits_of(int code);
        case (code)
            0: return 16;
            1: return 24;
            2: return 32;
            3: return 48;
            default: return -1;
        endcase
    endfunction

    // Reference model stepped on every edge, compared one time unit later.
    always @(posedge clk) begin
        int  half, nxt;
        bit  tk, run, fall;
        bit  eb, ef, efs, ebad, eoe;
        int  ei;
        if (!rst_n) begin
            m_root = 256; m_bfs = 32; m_pc = 0; m_hc = 0; m_idx = 63;
            m_bclk = 0; m_fclk = 0; m_fs = 0;
            s_idx = 63; s_fs = 0; s_fprev = 0;
            sb1 = 0; sb2 = 0; sbd = 0; sf1 = 0; sf2 = 0;
        end else begin
            half = (m_root % m_bfs == 0) ? (m_root / m_bfs) / 2 : 0;
            tk   = !psc_en || (m_pc == int'(psc_val));
            run  = !slave && (half != 0);
            m_fs = 0;
            if (!run) begin
                m_bclk = 0; m_fclk = 0; m_hc = 0; m_idx = 63;
            end else if (tk) begin
                if (m_hc >= half - 1) begin
                    m_hc = 0;
                    if (m_bclk) begin
                        nxt    = (m_idx >= m_bfs - 1) ? 0 : m_idx + 1;
                        m_idx  = nxt;
                        m_fclk = (nxt >= m_bfs / 2);
                        m_fs   = (nxt == 0);
                    end
                    m_bclk = !m_bclk;
                end else begin
                    m_hc++;
                end
            end
            m_pc = (!psc_en || tk) ? 0 : m_pc + 1;

            fall = sbd && !sb2;
            s_fs = 0;
            if (!slave) begin
                s_idx = 63; s_fprev = 0;
            end else if (fall) begin
                if (s_fprev && !sf2) begin
                    s_idx = 0; s_fs = 1;
                end else begin
                    s_idx = (s_idx + 1) % 64;
                end
                s_fprev = sf2;
            end
            sbd = sb2; sb2 = sb1; sb1 = bclk_ext;
            sf2 = sf1; sf1 = fclk_ext;

            m_root = root_of(int'(root_sel));
            if (bits_of(int'(bfs_sel)) > 0) m_bfs = bits_of(int'(bfs_sel));
        end
        #1;
        eb   = slave ? 1'b0 : m_bclk;
        ef   = slave ? 1'b0 : m_fclk;
        ei   = slave ? s_idx : m_idx;
        efs  = slave ? s_fs : m_fs;
        ebad = (m_root % m_bfs) != 0;
        eoe  = !slave;
        total++;
        if (bclk !== eb || fclk !== ef || int'(idx) != ei || fstart !== efs ||
            rbad !== ebad || oe !== eoe) begin
            bad++;
            $display("FAIL %s t=%0t actual bclk=%b fclk=%b idx=%0d fs=%b bad=%b oe=%b expected bclk=%b fclk=%b idx=%0d fs=%b bad=%b oe=%b",
                     tag, $time, bclk, fclk, idx, fstart, rbad, oe, eb, ef, ei, efs, ebad, eoe);
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=200000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // External clocks for slave mode: 8-clock bit period, frame of 32 bits.
    task automatic drive_slave(input int frames);
        for (int f = 0; f < frames; f++) begin
            for (int b = 0; b < 32; b++) begin
                fclk_ext = (b >= 16);
                bclk_ext = 1'b0;
                wait_cyc(4);
                bclk_ext = 1'b1;
                wait_cyc(4);
            end
        end
    endtask

    initial begin
        rst_n = 0; psc_en = 0; psc_val = 0; root_sel = 0; bfs_sel = 2;
        slave = 0; bclk_ext = 0; fclk_ext = 0;
        wait_cyc(3);
        // R10: reset state
        check("R10", int'(bclk), 0);
        check("R10", int'(idx), 63);
        check("R10", int'(rbad), 0);
        rst_n = 1;

        tag = "R4/R6/R7";
        wait_cyc(600);

        tag = "R3";
        psc_en = 1; psc_val = 2; root_sel = 1; bfs_sel = 3;
        wait_cyc(1500);

        tag = "R2";
        bfs_sel = 6;
        wait_cyc(400);
        check("R2", int'(rbad), 0);

        tag = "R5";
        root_sel = 5;
        wait_cyc(20);
        check("R5", int'(rbad), 1);
        check("R5", int'(idx), 63);
        wait_cyc(80);

        tag = "R1";
        psc_en = 0; root_sel = 3; bfs_sel = 1;
        wait_cyc(1000);

        tag = "R7";
        root_sel = 2; bfs_sel = 0;
        wait_cyc(600);

        tag = "R8";
        slave = 1;
        wait_cyc(2);
        check("R9", int'(oe), 0);
        drive_slave(3);
        wait_cyc(10);

        tag = "R9";
        slave = 0;
        wait_cyc(50);
        check("R9", int'(oe), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule